// File: doc/BRIEF.md
# Debug Breakpoint and Halt Controller

This block sits beside a small 8-bit microcontroller core and watches its execution. Each cycle it compares the fetch address and the data-memory access address against a set of comparators. It also watches the other break sources: a change in program flow, a stack-pointer overflow or underflow, a watchdog overflow, a core reset, and a decoded software-break opcode. When any enabled condition occurs it raises one halt request. That request stays high until the debug host sends a resume command.

There are two comparator banks:

- Four comparators match only on instruction fetches.
- Four more each carry a mode bit. In program mode they match fetches. In data mode they match data accesses, and only on cycles where the data strobe is high.

A simple register port lets a debug host do three things:

- load comparator addresses and enable bits;
- read back every setting;
- read the latched cause: one flag per source, plus the index of the lowest-numbered matching comparator.

The block never drives anything back into the core. With nothing enabled it has no effect at all.

Top module: `brk_halt_ctl`

## Requirements
- R1: After `rst_n` is low, `halt_req` is 0 and every readable register (addresses 0 to 11) reads 0.
- R2: Register map. Addresses 0-3 hold the fetch-only comparator addresses and 4-7 the mode-selectable ones. Address 8 holds the comparator enables, bit i for comparator i. Address 9 holds the mode bits, bit j for comparator 4+j, with 1 meaning data. Address 10 holds the source enables. Address 11 reads the cause. Values written to addresses 0-10 read back unchanged.
- R3: An enabled fetch-only comparator whose address equals `fetch_addr` while `fetch_vld` is high sets `halt_req` on the next edge. The cause then has bit 0 set and bits [10:8] set to the comparator index. A data access at that address does not match.
- R4: A mode-selectable comparator in data mode matches only when `dmem_stb` is high and `dmem_addr` equals its address; it ignores fetches. In program mode it behaves like a fetch-only comparator.
- R5: With source enable bit 5 set, `sw_brk` halts with cause bit 6.
- R6: With source enable bit 0 set, `flow_chg` halts with cause bit 1.
- R7: With source enable bits 1 and 2 set, `sp_ovf` and `sp_unf` halt with cause bits 2 and 3 respectively.
- R8: With source enable bit 3 set, `wdt_ovf` halts with cause bit 4.
- R9: With source enable bit 4 set, `core_rst` halts with cause bit 5.
- R10: With no comparator or source enabled, no input activity ever raises `halt_req`.
- R11: Once raised, `halt_req` and the cause stay fixed whatever events follow. Writing 1 in bit 0 to address 12 clears both at that edge.
- R12: When several conditions fire in one cycle, all of their cause bits are set, and the index reports the lowest-numbered matching comparator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| fetch_vld | input | 1 | A fetch occurs this cycle |
| fetch_addr | input | AW | Fetch address |
| dmem_stb | input | 1 | Data-memory access strobe |
| dmem_addr | input | AW | Data-memory access address |
| flow_chg | input | 1 | Next fetch is not the sequential successor |
| sp_ovf | input | 1 | Stack overflow event |
| sp_unf | input | 1 | Stack underflow event |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| core_rst | input | 1 | Core reset indication |
| sw_brk | input | 1 | Software-break opcode decoded |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | RA | Register write address |
| wr_data | input | RW | Register write data |
| rd_addr | input | RA | Register read address |
| rd_data | output | RW | Register read data (combinational) |
| halt_req | output | 1 | Halt request to the core |

## Verification
Halt and cause results fall due one clock edge after the cycle that carries the event. Register writes, including resume, take effect at the edge that samples them. Reads are combinational, so they are valid within the same cycle. The bench drives every input 1 ns after a rising edge and samples 1 ns after the next rising edge. It therefore checks `halt_req` and the cause exactly at the edge where the event is captured. It then keeps the halt for further cycles to confirm that the value holds.

// File: rtl/brk_halt_ctl.sv
module brk_halt_ctl #(
  parameter int AW = 16,
  parameter int NP = 4,
  parameter int NX = 4,
  parameter int RW = 16,
  parameter int RA = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_vld,
  input  logic [AW-1:0] fetch_addr,
  input  logic          dmem_stb,
  input  logic [AW-1:0] dmem_addr,
  input  logic          flow_chg,
  input  logic          sp_ovf,
  input  logic          sp_unf,
  input  logic          wdt_ovf,
  input  logic          core_rst,
  input  logic          sw_brk,
  input  logic          wr_en,
  input  logic [RA-1:0] wr_addr,
  input  logic [RW-1:0] wr_data,
  input  logic [RA-1:0] rd_addr,
  output logic [RW-1:0] rd_data,
  output logic          halt_req
);
  localparam int NC = NP + NX;
  localparam int IW = (NC > 1) ? $clog2(NC) : 1;
  localparam int NS = 6;
  localparam int NF = NS + 1;
  localparam int A_EN = NC;
  localparam int A_MODE = NC + 1;
  localparam int A_SRC = NC + 2;
  localparam int A_CAUSE = NC + 3;
  localparam int A_CMD = NC + 4;

  logic [AW-1:0] cmp_addr [NC];
  logic [NC-1:0] cmp_en;
  logic [NX-1:0] xmode;
  logic [NS-1:0] src_en;
  logic [NF-1:0] cause_flags;
  logic [IW-1:0] cause_idx;
  logic [NC-1:0] hit;
  logic [IW-1:0] hit_idx;
  logic [NF-1:0] flags;
  logic          resume;
  logic [RW-1:0] cause_rd;

  for (genvar i = 0; i < NP; i++) begin : g_prog
    assign hit[i] = cmp_en[i] && fetch_vld && (fetch_addr == cmp_addr[i]);
  end

  for (genvar j = 0; j < NX; j++) begin : g_flex
    assign hit[NP+j] = cmp_en[NP+j] &&
      (xmode[j] ? (dmem_stb && dmem_addr == cmp_addr[NP+j])
                : (fetch_vld && fetch_addr == cmp_addr[NP+j]));
  end

  always_comb begin
    hit_idx = '0;
    for (int k = NC - 1; k >= 0; k--)
      if (hit[k]) hit_idx = IW'(k);
  end

  assign flags  = {({sw_brk, core_rst, wdt_ovf, sp_unf, sp_ovf, flow_chg} & src_en), |hit};
  assign resume = wr_en && (wr_addr == RA'(A_CMD)) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) cmp_addr[i] <= '0;
      cmp_en <= '0;
      xmode  <= '0;
      src_en <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NC; i++)
        if (wr_addr == RA'(i)) cmp_addr[i] <= wr_data[AW-1:0];
      if (wr_addr == RA'(A_EN))   cmp_en <= wr_data[NC-1:0];
      if (wr_addr == RA'(A_MODE)) xmode  <= wr_data[NX-1:0];
      if (wr_addr == RA'(A_SRC))  src_en <= wr_data[NS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_req    <= 1'b0;
      cause_flags <= '0;
      cause_idx   <= '0;
    end else if (resume) begin
      halt_req    <= 1'b0;
      cause_flags <= '0;
      cause_idx   <= '0;
    end else if (!halt_req && (|flags)) begin
      halt_req    <= 1'b1;
      cause_flags <= flags;
      cause_idx   <= hit[hit_idx] ? hit_idx : '0;
    end
  end

  assign cause_rd = RW'({cause_idx, 1'b0, cause_flags});

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NC; i++)
      if (rd_addr == RA'(i)) rd_data = RW'(cmp_addr[i]);
    if (rd_addr == RA'(A_EN))    rd_data = RW'(cmp_en);
    if (rd_addr == RA'(A_MODE))  rd_data = RW'(xmode);
    if (rd_addr == RA'(A_SRC))   rd_data = RW'(src_en);
    if (rd_addr == RA'(A_CAUSE)) rd_data = cause_rd;
  end
endmodule

module brk_halt_ctl_chk #(
  parameter int NF = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          halt_req,
  input logic          resume,
  input logic [NF-1:0] cause_flags,
  input logic          any_en,
  input logic          wdt_on,
  input logic          wdt_ovf
);
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (halt_req && !resume) |=> halt_req); // R11
  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (halt_req && !resume) |=> $stable(cause_flags)); // R11
  AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) resume |=> (!halt_req && cause_flags == '0)); // R11
  AST_QUIET_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n) (!any_en && !halt_req) |=> !halt_req); // R10
  AST_WDT_HALTS: assert property (@(posedge clk) disable iff (!rst_n) (wdt_on && wdt_ovf && !halt_req && !resume) |=> (halt_req && cause_flags[4])); // R8
  AST_HALT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) halt_req |-> (cause_flags != '0)); // R12
endmodule

bind brk_halt_ctl brk_halt_ctl_chk #(.NF(NF)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .halt_req(halt_req),
  .resume(resume),
  .cause_flags(cause_flags),
  .any_en((|cmp_en) || (|src_en)),
  .wdt_on(src_en[3]),
  .wdt_ovf(wdt_ovf)
);

// File: tb/brk_halt_ctl_test.sv
module brk_halt_ctl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        fetch_vld = 0, dmem_stb = 0;
  logic [15:0] fetch_addr = 0, dmem_addr = 0;
  logic        flow_chg = 0, sp_ovf = 0, sp_unf = 0, wdt_ovf = 0, core_rst = 0, sw_brk = 0;
  logic        wr_en = 0;
  logic [3:0]  wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic        halt_req;
  int errors = 0, checks = 0;

  brk_halt_ctl uut (.*);

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic idle();
    fetch_vld = 0; dmem_stb = 0; flow_chg = 0; sp_ovf = 0; sp_unf = 0;
    wdt_ovf = 0; core_rst = 0; sw_brk = 0; wr_en = 0;
  endtask

  task automatic step();
    @(posedge clk); #1; idle();
  endtask

  task automatic wr(int a, logic [15:0] d);
    wr_en = 1; wr_addr = 4'(a); wr_data = d; step();
  endtask

  task automatic rd(string tag, int a, logic [15:0] exp);
    rd_addr = 4'(a); #1; chk(tag, rd_data, exp);
  endtask

  task automatic clear_all();
    for (int i = 0; i < 11; i++) wr(i, 16'h0);
    wr(12, 16'h1);
  endtask

  task automatic t_reset();
    chk("R1 halt after reset", halt_req, 0);
    for (int i = 0; i < 12; i++) rd("R1 reg zero after reset", i, 16'h0);
  endtask

  task automatic t_regs();
    for (int i = 0; i < 8; i++) wr(i, 16'hA500 + 16'(i));
    wr(8, 16'h00C3); wr(9, 16'h000A); wr(10, 16'h002D);
    for (int i = 0; i < 8; i++) rd("R2 cmp addr readback", i, 16'hA500 + 16'(i));
    rd("R2 enable readback", 8, 16'h00C3);
    rd("R2 mode readback", 9, 16'h000A);
    rd("R2 source readback", 10, 16'h002D);
    chk("R10 no halt with sources idle", halt_req, 0);
    clear_all();
  endtask

  task automatic t_prog_cmp();
    wr(2, 16'h1234); wr(8, 16'h0004);
    fetch_vld = 1; fetch_addr = 16'h1233; step();
    chk("R3 near address no halt", halt_req, 0);
    dmem_stb = 1; dmem_addr = 16'h1234; step();
    chk("R3 data access ignored", halt_req, 0);
    fetch_vld = 1; fetch_addr = 16'h1234; step();
    chk("R3 fetch hit halts", halt_req, 1);
    rd("R3 cause cmp idx 2", 11, 16'h0201);
    wr(10, 16'h003F);
    wdt_ovf = 1; sw_brk = 1; flow_chg = 1; step();
    step();
    chk("R11 halt holds", halt_req, 1);
    rd("R11 cause holds", 11, 16'h0201);
    wr(12, 16'h1);
    chk("R11 resume clears halt", halt_req, 0);
    rd("R11 resume clears cause", 11, 16'h0);
    clear_all();
  endtask

  task automatic t_flex();
    wr(5, 16'h0040); wr(9, 16'h0002); wr(8, 16'h0020);
    fetch_vld = 1; fetch_addr = 16'h0040; step();
    chk("R4 data mode ignores fetch", halt_req, 0);
    dmem_addr = 16'h0040; step();
    chk("R4 data mode needs strobe", halt_req, 0);
    dmem_stb = 1; dmem_addr = 16'h0040; step();
    chk("R4 data mode hit", halt_req, 1);
    rd("R4 cause idx 5", 11, 16'h0501);
    wr(12, 16'h1);
    wr(9, 16'h0000);
    dmem_stb = 1; dmem_addr = 16'h0040; step();
    chk("R4 program mode ignores data", halt_req, 0);
    fetch_vld = 1; fetch_addr = 16'h0040; step();
    chk("R4 program mode fetch hit", halt_req, 1);
    rd("R4 cause idx 5 program", 11, 16'h0501);
    clear_all();
  endtask

  task automatic fire(int k);
    case (k)
      0: flow_chg = 1;
      1: sp_ovf = 1;
      2: sp_unf = 1;
      3: wdt_ovf = 1;
      4: core_rst = 1;
      default: sw_brk = 1;
    endcase
  endtask

  task automatic t_sources();
    string tags [6] = '{"R6 flow", "R7 stack ovf", "R7 stack unf", "R8 watchdog", "R9 core reset", "R5 sw break"};
    for (int k = 0; k < 6; k++) begin
      wr(10, 16'h003F & ~(16'h1 << k));
      fire(k); step();
      chk({tags[k], " disabled no halt"}, halt_req, 0);
      wr(10, 16'h1 << k);
      fire(k); step();
      chk({tags[k], " halts"}, halt_req, 1);
      rd({tags[k], " cause bit"}, 11, 16'h1 << (k + 1));
      wr(12, 16'h1);
    end
    clear_all();
  endtask

  task automatic t_quiet();
    wr(0, 16'h0010); wr(4, 16'h0020);
    for (int n = 0; n < 6; n++) begin
      fetch_vld = 1; fetch_addr = 16'h0010; dmem_stb = 1; dmem_addr = 16'h0020;
      fire(n); flow_chg = 1; step();
    end
    chk("R10 no enables no halt", halt_req, 0);
    rd("R10 cause stays clear", 11, 16'h0);
    clear_all();
  endtask

  task automatic t_multi();
    wr(1, 16'h0100); wr(6, 16'h0100); wr(3, 16'h0100);
    wr(8, 16'h004A); wr(10, 16'h0008);
    fetch_vld = 1; fetch_addr = 16'h0100; wdt_ovf = 1; step();
    chk("R12 multi halts", halt_req, 1);
    rd("R12 all bits lowest idx", 11, 16'h0111);
    wr(12, 16'h1);
    wr(8, 16'h0048);
    fetch_vld = 1; fetch_addr = 16'h0100; step();
    rd("R12 lowest idx 3", 11, 16'h0301);
    clear_all();
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    #22 rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_regs();
    t_prog_cmp();
    t_flex();
    t_sources();
    t_quiet();
    t_multi();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule